// File: doc/BRIEF.md
# Bit Set/Clear Control Register

This block is a control register that software changes one bit at a time without a read-modify-write sequence. It takes three consecutive addresses on a simple synchronous register bus. A write to the first address turns on the bits that carry a one in the write data. A write to the second address turns off the bits that carry a one. The third address is read-only and returns the stored value.

The stored word also drives a parallel output that goes straight to the logic the register controls. The first of the three addresses is a parameter, so several copies can sit next to each other in one register map, each decoding its own triple. Each copy stores the word and does nothing else with it.

Top module: `scr_triple`

## Requirements
- R1: The block decodes three addresses: `BASE_ADDR` sets bits, `BASE_ADDR+1` clears bits and `BASE_ADDR+2` returns the stored value.
- R2: A write to the set address makes the stored value equal to the old value OR the write data.
- R3: A write to the clear address makes the stored value equal to the old value AND the inverted write data.
- R4: A bit whose write-data position is zero keeps its value through a set or clear write.
- R5: While the status address is on the bus, the read data equals the stored value in that same cycle. A set or clear write shows up in the read data on the cycle after the write edge.
- R6: A write to the status address, or to any address outside the triple, leaves the stored value unchanged.
- R7: The read data is zero whenever the address is the set address, the clear address or any address outside the triple.
- R8: Reset (active-low `rstN`) clears the stored value to all zeros.
- R9: The `regValue` output always equals the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register bus address |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | DATA_W | Write data; ones pick the bits that change |
| busRdData | output | DATA_W | Read data, combinational from the address |
| regValue | output | DATA_W | Stored value sent to the controlled logic |

## Verification
The bench writes patterns where some bits are already set and others are clear, so that an implementation that copies the write data instead of merging it breaks R2, R3 and R4. It writes to the status address and to addresses just below and above the triple. A decoder that ignores the base offset, or that treats the status address as writable, then visibly changes `regValue`. Reads of the set and clear addresses must return zero. A read taken the cycle after each write catches an update that arrives one cycle late.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Strobes from the decoder to the storage datapath
  typedef struct packed {
    logic setStb;   // write to set address
    logic clrStb;   // write to clear address
    logic rdSel;    // status address on the bus
  } scrStrobes_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output scrStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(BASE_ADDR + 2);

  logic hitSet;
  logic hitClr;
  logic hitSts;

  always_comb begin
    hitSet = (busAddr == SET_ADDR);
    hitClr = (busAddr == CLR_ADDR);
    hitSts = (busAddr == STS_ADDR);
    strobes.setStb = busWrEn & hitSet;
    strobes.clrStb = busWrEn & hitClr;
    // status is read-only: a write there raises no strobe
    strobes.rdSel  = hitSts;
  end
endmodule

// File: rtl/scr_data.sv
module scr_data
  import scr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  scrStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] nextVal;

  always_comb begin
    nextVal = stored;
    if (strobes.setStb) nextVal = stored | wrData;
    else if (strobes.clrStb) nextVal = stored & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stored <= '0;
    else       stored <= nextVal;
  end

  assign rdData = strobes.rdSel ? stored : '0;
  assign value  = stored;
endmodule

// File: rtl/scr_triple.sv
module scr_triple
  import scr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] regValue
);
  scrStrobes_t strobes;

  scr_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  scr_data #(.DATA_W(DATA_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .value   (regValue)
  );
endmodule

// File: rtl/scr_triple_chk.sv
module scr_triple_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] regValue
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(BASE_ADDR + 2);

  AST_SET_MERGES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == SET_A) |=> (regValue == ($past(regValue) | $past(busWrData)))); // R2
  AST_CLR_MERGES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CLR_A) |=> (regValue == ($past(regValue) & ~$past(busWrData)))); // R3
  AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != SET_A && busAddr != CLR_A) |=> $stable(regValue)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(regValue)); // R4
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == STS_A) |-> (busRdData == regValue)); // R5
  AST_NONSTATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != STS_A) |-> (busRdData == '0)); // R7
endmodule

bind scr_triple scr_triple_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) i_scr_triple_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .regValue(regValue)
);

// File: tb/test_scr_triple.sv
module test_scr_triple;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int BASE = 4;
  localparam logic [AW-1:0] A_SET = AW'(BASE);
  localparam logic [AW-1:0] A_CLR = AW'(BASE + 1);
  localparam logic [AW-1:0] A_STS = AW'(BASE + 2);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic [DW-1:0] regValue;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model = '0;

  always #4 clk = ~clk;

  scr_triple #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) i_scr_triple (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .regValue(regValue)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write drives at a falling edge; the rising edge in between commits it
  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    if (a == A_SET) model = model | d;
    else if (a == A_CLR) model = model & ~d;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic testReset();
    logic [DW-1:0] r;
    check("R8 reset value", regValue, '0);
    busRead(A_STS, r);
    check("R8 reset read", r, '0);
  endtask

  task automatic testSet();
    logic [DW-1:0] r;
    busWrite(A_SET, 32'h0000_00F0);
    busRead(A_STS, r);
    check("R2 R5 set from zero", r, 32'h0000_00F0);
    busWrite(A_SET, 32'h8000_000F);
    busRead(A_STS, r);
    check("R2 set merges", r, 32'h8000_00FF);
    check("R9 output follows", regValue, model);
  endtask

  task automatic testClear();
    logic [DW-1:0] r;
    busWrite(A_CLR, 32'h0000_003C);
    busRead(A_STS, r);
    check("R3 clear merges", r, 32'h8000_00C3);
    busWrite(A_CLR, 32'h8000_0000);
    busRead(A_STS, r);
    check("R3 clear top bit", r, 32'h0000_00C3);
  endtask

  task automatic testZeros();
    busWrite(A_SET, '0);
    check("R4 zero set write", regValue, 32'h0000_00C3);
    busWrite(A_CLR, '0);
    check("R4 zero clear write", regValue, 32'h0000_00C3);
  endtask

  task automatic testIgnored();
    busWrite(A_STS, 32'hFFFF_FFFF);
    check("R6 status write ignored", regValue, 32'h0000_00C3);
    busWrite(AW'(BASE - 1), 32'hFFFF_FFFF);
    check("R6 below triple ignored", regValue, 32'h0000_00C3);
    busWrite(AW'(BASE + 3), 32'hFFFF_FFFF);
    check("R6 above triple ignored", regValue, 32'h0000_00C3);
    busWrite(AW'(0), 32'hFFFF_FFFF);
    check("R1 base offset decode", regValue, 32'h0000_00C3);
  endtask

  task automatic testReadZero();
    logic [DW-1:0] r;
    busRead(A_SET, r);
    check("R7 set addr reads zero", r, '0);
    busRead(A_CLR, r);
    check("R7 clear addr reads zero", r, '0);
    busRead(AW'(BASE + 3), r);
    check("R7 outside addr reads zero", r, '0);
    busRead(A_STS, r);
    check("R1 status addr reads value", r, model);
  endtask

  task automatic testFull();
    logic [DW-1:0] r;
    busWrite(A_SET, 32'hFFFF_FFFF);
    busRead(A_STS, r);
    check("R2 set all", r, 32'hFFFF_FFFF);
    busWrite(A_CLR, 32'h5555_5555);
    busRead(A_STS, r);
    check("R3 alternating clear", r, 32'hAAAA_AAAA);
    check("R9 model match", regValue, model);
  endtask

  task automatic testReReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R8 async reset", regValue, '0);
    @(negedge clk);
    rstN = 1'b1;
    model = '0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testSet();
    testClear();
    testZeros();
    testIgnored();
    testReadZero();
    testFull();
    testReReset();
    testSet();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule